// File: doc/BRIEF.md
# Interface Wakeup Generator

This block produces the power wakeup hints for one AXI-style master interface and for one snoop channel that an interconnect drives toward an upstream cache-holding master. The hint tells the receiving side that a request is waiting, or is about to wait. Raising it early lets the receiver start leaving its low-power state while the request is still being prepared.

Each address channel (read, write, snoop) can take an optional one-cycle "intent" pulse ahead of its valid. An intent sets a registered pending flag. The flag clears on the address handshake of that channel, so the hint is not held for the rest of the transaction. From then on, a per-channel outstanding counter keeps the busy output high until the final completion of that transaction. A valid that arrives without any intent drives the hint high in the same cycle. The same holds for a write-data valid, so the interface also works when no source of intents is wired up.

The busy outputs are meant for a local power controller, which must not gate the interface while busy is high. The block does not gate clocks or power itself.

Top module: `iface_wake_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with all inputs low, every wake and busy output is 0.
- R2: An intent pulse on the read or write address channel makes `mst_wake` 1 from the next cycle on, and it stays 1 until the handshake on that channel. An intent on the snoop channel does the same for `snp_wake`.
- R3: In the cycle after an address handshake (valid and ready both 1), the pending flag of that channel is clear. If no other intent, pending flag or valid is present, the wake output is 0.
- R4: `mst_wake` is 1 in any cycle where `ar_valid`, `aw_valid` or `w_valid` is 1, whether or not an intent came first.
- R5: An intent in the same cycle as a handshake on that channel keeps the wake output at 1 in the following cycle.
- R6: The snoop channel drives only `snp_wake` and `snp_busy`. Read and write activity drives only `mst_wake` and `mst_busy`.
- R7: Each read or write address handshake adds one outstanding transaction. Each `rd_cmpl` or `wr_cmpl` pulse retires one. `mst_busy` is 1 while any read or write is outstanding.
- R8: Each snoop handshake adds one outstanding snoop and each `sn_cmpl` retires one. `snp_busy` is 1 while any snoop is outstanding.
- R9: Each busy output is 1 in every cycle where the matching wake output is 1, even with nothing outstanding.
- R10: A handshake and a completion on the same channel in the same cycle leave that channel's outstanding count unchanged.
- R11: A ready without a valid neither clears a pending wake nor changes an outstanding count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ar_intent | input | 1 | Early notice that a read request will follow |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| aw_intent | input | 1 | Early notice that a write request will follow |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| w_valid | input | 1 | Write data valid |
| rd_cmpl | input | 1 | Final read response accepted, one pulse per read |
| wr_cmpl | input | 1 | Write response accepted, one pulse per write |
| sn_intent | input | 1 | Early notice that a snoop will follow |
| sn_valid | input | 1 | Snoop address valid |
| sn_ready | input | 1 | Snoop address ready |
| sn_cmpl | input | 1 | Snoop response accepted, one pulse per snoop |
| mst_wake | output | 1 | Wakeup hint on the master interface |
| snp_wake | output | 1 | Wakeup hint on the snoop channel |
| mst_busy | output | 1 | Master interface must stay awake |
| snp_busy | output | 1 | Snoop channel must stay awake |

## Verification
The properties assume that a completion pulse only arrives while its channel has something outstanding. They also assume that a channel never has more transactions outstanding than its limit parameter. The random stimulus keeps both rules by using a model of the counts: it raises a completion only when the modelled count is non-zero, and it holds ready low once the count reaches its limit. Within those limits, intents, valids, readies and write-data valids are drawn independently, so intents coincide freely with handshakes and with completions.

// File: rtl/wk_pkg.sv
package wk_pkg;

   // One address channel as seen by the wakeup logic
   typedef struct packed {
      logic intent;
      logic valid;
      logic ready;
   } wk_addr_ch_t;

   // Channel indices inside the top module
   localparam int WK_CH_RD = 0;
   localparam int WK_CH_WR = 1;
   localparam int WK_CH_SN = 2;
   localparam int WK_NUM_CH = 3;

   // Bits needed to hold a count from 0 to max_outst
   function automatic int cnt_width(input int max_outst);
      return (max_outst < 1) ? 1 : $clog2(max_outst + 1);
   endfunction

   // Outstanding limit for a channel index
   function automatic int chan_limit(input int idx, input int rd_max,
                                     input int wr_max, input int sn_max);
      return (idx == WK_CH_RD) ? rd_max : (idx == WK_CH_WR) ? wr_max : sn_max;
   endfunction

endpackage

// File: rtl/wk_chan_track.sv
module wk_chan_track #(
   parameter bit USE_INTENT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic intent,
   input  logic valid,
   input  logic hs,
   output logic wake
);

   generate
      if (USE_INTENT) begin : g_intent
         logic pend_q;
         // A new intent wins over the handshake that retires the old request
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= intent | (pend_q & ~hs);
         end
         assign wake = pend_q | valid;
      end else begin : g_valid_only
         logic unused_inputs;
         assign unused_inputs = intent ^ hs ^ clk ^ rst_n;
         assign wake = valid;
      end
   endgenerate

endmodule

// File: rtl/wk_outst_cnt.sv
module wk_outst_cnt #(
   parameter int MAX_OUTST = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic nz
);
   localparam int CW = wk_pkg::cnt_width(MAX_OUTST);

   if (MAX_OUTST < 1) begin : g_bad_limit
      $error("wk_outst_cnt: MAX_OUTST must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign nz = |cnt_q;

endmodule

// File: rtl/iface_wake_gen.sv
module iface_wake_gen
   import wk_pkg::*;
#(
   parameter bit USE_INTENT   = 1'b1,
   parameter int RD_MAX_OUTST = 8,
   parameter int WR_MAX_OUTST = 8,
   parameter int SN_MAX_OUTST = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ar_intent,
   input  logic ar_valid,
   input  logic ar_ready,
   input  logic aw_intent,
   input  logic aw_valid,
   input  logic aw_ready,
   input  logic w_valid,
   input  logic rd_cmpl,
   input  logic wr_cmpl,
   input  logic sn_intent,
   input  logic sn_valid,
   input  logic sn_ready,
   input  logic sn_cmpl,
   output logic mst_wake,
   output logic snp_wake,
   output logic mst_busy,
   output logic snp_busy
);

   if (RD_MAX_OUTST < 1 || WR_MAX_OUTST < 1 || SN_MAX_OUTST < 1) begin : g_bad_cfg
      $error("iface_wake_gen: every outstanding limit must be at least 1");
   end

   wk_addr_ch_t          ch [WK_NUM_CH];
   logic [WK_NUM_CH-1:0] ch_hs;
   logic [WK_NUM_CH-1:0] ch_wake;
   logic [WK_NUM_CH-1:0] ch_cmpl;
   logic [WK_NUM_CH-1:0] ch_outst;

   assign ch[WK_CH_RD] = '{intent: ar_intent, valid: ar_valid, ready: ar_ready};
   assign ch[WK_CH_WR] = '{intent: aw_intent, valid: aw_valid, ready: aw_ready};
   assign ch[WK_CH_SN] = '{intent: sn_intent, valid: sn_valid, ready: sn_ready};

   assign ch_cmpl[WK_CH_RD] = rd_cmpl;
   assign ch_cmpl[WK_CH_WR] = wr_cmpl;
   assign ch_cmpl[WK_CH_SN] = sn_cmpl;

   for (genvar i = 0; i < WK_NUM_CH; i++) begin : g_ch
      localparam int LIMIT = chan_limit(i, RD_MAX_OUTST, WR_MAX_OUTST, SN_MAX_OUTST);

      assign ch_hs[i] = ch[i].valid & ch[i].ready;

      wk_chan_track #(
         .USE_INTENT (USE_INTENT)
      ) u_trk (
         .clk    (clk),
         .rst_n  (rst_n),
         .intent (ch[i].intent),
         .valid  (ch[i].valid),
         .hs     (ch_hs[i]),
         .wake   (ch_wake[i])
      );

      wk_outst_cnt #(
         .MAX_OUTST (LIMIT)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (ch_hs[i]),
         .dec   (ch_cmpl[i]),
         .nz    (ch_outst[i])
      );
   end

   // Write data has no intent of its own; its valid alone raises the hint
   assign mst_wake = ch_wake[WK_CH_RD] | ch_wake[WK_CH_WR] | w_valid;
   assign snp_wake = ch_wake[WK_CH_SN];

   assign mst_busy = mst_wake | ch_outst[WK_CH_RD] | ch_outst[WK_CH_WR];
   assign snp_busy = snp_wake | ch_outst[WK_CH_SN];

endmodule

// File: rtl/iface_wake_gen_chk.sv
module iface_wake_gen_chk #(
   parameter bit USE_INTENT = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic ar_intent,
   input logic ar_valid,
   input logic ar_ready,
   input logic aw_intent,
   input logic aw_valid,
   input logic aw_ready,
   input logic w_valid,
   input logic sn_intent,
   input logic sn_valid,
   input logic sn_ready,
   input logic mst_wake,
   input logic snp_wake,
   input logic mst_busy,
   input logic snp_busy
);

   if (USE_INTENT) begin : g_intent_props
      p_wake_on_intent_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (ar_intent || aw_intent) |=> mst_wake);
      p_snp_wake_on_intent_r2: assert property (@(posedge clk) disable iff (!rst_n)
         sn_intent |=> snp_wake);
   end

   p_drop_after_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mst_wake) |-> $past(ar_valid || aw_valid || w_valid));

   p_wake_on_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_valid || aw_valid || w_valid) |-> mst_wake);

   p_snp_wake_on_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sn_valid |-> snp_wake);

   p_busy_after_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((ar_valid && ar_ready) || (aw_valid && aw_ready)) |=> mst_busy);

   p_snp_busy_after_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sn_valid && sn_ready) |=> snp_busy);

   p_busy_covers_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_wake |-> mst_busy) and (snp_wake |-> snp_busy));

endmodule

bind iface_wake_gen iface_wake_gen_chk #(
   .USE_INTENT (USE_INTENT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ar_intent (ar_intent),
   .ar_valid  (ar_valid),
   .ar_ready  (ar_ready),
   .aw_intent (aw_intent),
   .aw_valid  (aw_valid),
   .aw_ready  (aw_ready),
   .w_valid   (w_valid),
   .sn_intent (sn_intent),
   .sn_valid  (sn_valid),
   .sn_ready  (sn_ready),
   .mst_wake  (mst_wake),
   .snp_wake  (snp_wake),
   .mst_busy  (mst_busy),
   .snp_busy  (snp_busy)
);

// File: tb/iface_wake_gen_bench.sv
`timescale 1ns/1ps
module iface_wake_gen_bench;

   localparam int RD_MAX = 8;
   localparam int WR_MAX = 8;
   localparam int SN_MAX = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ar_intent, ar_valid, ar_ready;
   logic aw_intent, aw_valid, aw_ready, w_valid;
   logic rd_cmpl, wr_cmpl;
   logic sn_intent, sn_valid, sn_ready, sn_cmpl;
   logic mst_wake, snp_wake, mst_busy, snp_busy;

   int checks = 0;
   int fails  = 0;

   // bench model state
   bit m_par, m_paw, m_psn;
   int m_rd, m_wr, m_sn;

   always #2.5 clk = ~clk;

   iface_wake_gen #(
      .USE_INTENT   (1'b1),
      .RD_MAX_OUTST (RD_MAX),
      .WR_MAX_OUTST (WR_MAX),
      .SN_MAX_OUTST (SN_MAX)
   ) u_iface_wake_gen (
      .clk (clk), .rst_n (rst_n),
      .ar_intent (ar_intent), .ar_valid (ar_valid), .ar_ready (ar_ready),
      .aw_intent (aw_intent), .aw_valid (aw_valid), .aw_ready (aw_ready),
      .w_valid (w_valid), .rd_cmpl (rd_cmpl), .wr_cmpl (wr_cmpl),
      .sn_intent (sn_intent), .sn_valid (sn_valid), .sn_ready (sn_ready),
      .sn_cmpl (sn_cmpl),
      .mst_wake (mst_wake), .snp_wake (snp_wake),
      .mst_busy (mst_busy), .snp_busy (snp_busy)
   );

   function automatic bit exp_mw();
      return m_par | m_paw | ar_valid | aw_valid | w_valid;
   endfunction
   function automatic bit exp_sw();
      return m_psn | sn_valid;
   endfunction
   function automatic bit exp_mb();
      return exp_mw() | (m_rd != 0) | (m_wr != 0);
   endfunction
   function automatic bit exp_sb();
      return exp_sw() | (m_sn != 0);
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic clr();
      ar_intent = 0; ar_valid = 0; ar_ready = 0;
      aw_intent = 0; aw_valid = 0; aw_ready = 0; w_valid = 0;
      rd_cmpl = 0; wr_cmpl = 0;
      sn_intent = 0; sn_valid = 0; sn_ready = 0; sn_cmpl = 0;
   endtask

   // check the current cycle, advance the model, move to next drive point
   task automatic cyc(input string tag);
      bit hs_ar, hs_aw, hs_sn;
      #1;
      chk({tag, " mst_wake"}, mst_wake, exp_mw());
      chk({tag, " snp_wake"}, snp_wake, exp_sw());
      chk({tag, " mst_busy"}, mst_busy, exp_mb());
      chk({tag, " snp_busy"}, snp_busy, exp_sb());
      hs_ar = ar_valid & ar_ready;
      hs_aw = aw_valid & aw_ready;
      hs_sn = sn_valid & sn_ready;
      m_par = ar_intent | (m_par & !hs_ar);
      m_paw = aw_intent | (m_paw & !hs_aw);
      m_psn = sn_intent | (m_psn & !hs_sn);
      m_rd  = m_rd + int'(hs_ar) - int'(rd_cmpl);
      m_wr  = m_wr + int'(hs_aw) - int'(wr_cmpl);
      m_sn  = m_sn + int'(hs_sn) - int'(sn_cmpl);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'h00C0FFEE);
      clr();
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset mst_wake", mst_wake, 1'b0);
      chk("R1 reset snp_wake", snp_wake, 1'b0);
      chk("R1 reset mst_busy", mst_busy, 1'b0);
      chk("R1 reset snp_busy", snp_busy, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R1 after reset");

      // R2 / R3 / R7: intent, wait, handshake, completion
      ar_intent = 1; cyc("R2 intent cycle");
      clr(); cyc("R2 wake after intent");
      chk("R2 held mst_wake", mst_wake, 1'b1);
      cyc("R2 still held");
      ar_ready = 1; cyc("R11 ready without valid");
      chk("R11 wake kept", mst_wake, 1'b1);
      ar_ready = 0; ar_valid = 1; cyc("R2 valid waiting");
      ar_ready = 1; cyc("R3 handshake");
      clr(); cyc("R3 wake dropped");
      chk("R3 mst_wake low", mst_wake, 1'b0);
      chk("R7 busy outstanding", mst_busy, 1'b1);
      rd_cmpl = 1; cyc("R7 completion");
      clr(); cyc("R7 idle");
      chk("R7 busy cleared", mst_busy, 1'b0);

      // R4: valid without intent, write path
      aw_valid = 1; aw_ready = 1; #1;
      chk("R4 same-cycle wake", mst_wake, 1'b1);
      cyc("R4 aw no intent");
      clr(); w_valid = 1; #1;
      chk("R4 w_valid wake", mst_wake, 1'b1);
      cyc("R4 w_valid");
      clr(); cyc("R7 write outstanding");
      chk("R7 write busy", mst_busy, 1'b1);
      wr_cmpl = 1; cyc("R7 write done");
      clr(); cyc("R7 write idle");

      // R5: intent during handshake
      aw_intent = 1; cyc("R5 first intent");
      clr(); aw_valid = 1; aw_ready = 1; aw_intent = 1; cyc("R5 hs with intent");
      clr(); cyc("R5 wake kept");
      chk("R5 mst_wake held", mst_wake, 1'b1);
      aw_valid = 1; aw_ready = 1; cyc("R5 second hs");
      clr(); wr_cmpl = 1; cyc("R5 retire one");
      wr_cmpl = 1; cyc("R5 retire two");
      clr(); cyc("R5 idle");
      chk("R5 idle busy", mst_busy, 1'b0);

      // R6 / R8: snoop channel independent
      sn_intent = 1; cyc("R6 snoop intent");
      clr(); cyc("R6 snoop wake");
      chk("R6 snp_wake", snp_wake, 1'b1);
      chk("R6 mst_wake untouched", mst_wake, 1'b0);
      sn_valid = 1; sn_ready = 1; cyc("R8 snoop hs");
      clr(); cyc("R8 snoop outstanding");
      chk("R8 snp_busy", snp_busy, 1'b1);
      chk("R6 mst_busy untouched", mst_busy, 1'b0);
      sn_cmpl = 1; cyc("R8 snoop done");
      clr(); cyc("R8 idle");

      // R9: busy from wake alone
      ar_intent = 1; cyc("R9 intent");
      clr(); cyc("R9 busy from wake");
      chk("R9 mst_busy", mst_busy, 1'b1);
      ar_valid = 1; ar_ready = 1; cyc("R10 first hs");
      // R10: handshake and completion together
      ar_valid = 1; ar_ready = 1; rd_cmpl = 1; cyc("R10 hs plus cmpl");
      clr(); cyc("R10 count kept");
      chk("R10 busy kept", mst_busy, 1'b1);
      rd_cmpl = 1; cyc("R10 retire");
      clr(); cyc("R10 idle");
      chk("R10 busy cleared", mst_busy, 1'b0);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         ar_intent = ($urandom % 6) == 0;
         aw_intent = ($urandom % 6) == 0;
         sn_intent = ($urandom % 8) == 0;
         ar_valid  = ($urandom % 2) == 0;
         aw_valid  = ($urandom % 3) == 0;
         sn_valid  = ($urandom % 3) == 0;
         w_valid   = ($urandom % 4) == 0;
         ar_ready  = (m_rd < RD_MAX) && (($urandom % 2) == 0);
         aw_ready  = (m_wr < WR_MAX) && (($urandom % 2) == 0);
         sn_ready  = (m_sn < SN_MAX) && (($urandom % 2) == 0);
         rd_cmpl   = (m_rd > 0) && (($urandom % 3) == 0);
         wr_cmpl   = (m_wr > 0) && (($urandom % 3) == 0);
         sn_cmpl   = (m_sn > 0) && (($urandom % 3) == 0);
         cyc("R2 R3 R4 R5 R7 R8 R9 R10 random");
      end

      summary();
      $finish;
   end

endmodule